// File: doc/BRIEF.md
# Two-Level Multiprocessor Interrupt Prioritizer

This block collects interrupt events from a shared 16-line interrupt bus into one pending register for the whole system. Only lines 1 to 15 carry requests; line 0 is dropped. A one-clock pulse is enough to record an event, and the event stays recorded after the line falls. Each source is given a priority level, 0 or 1, in a level register. Level 1 always wins over level 0. Within a level, the higher line number wins.

Every processor has its own mask register and its own force register. For each processor the block forms a candidate set: the pending bits ORed with that processor's force bits, then ANDed with its mask. It picks the winner and drives it as a registered 4-bit request number. The value 0 means that no interrupt is requested. A processor acknowledges by returning the number it serviced. The acknowledge clears that processor's force bit if the bit is set, and otherwise clears the pending bit. A single write port sets or clears bits in any of these registers.

Top module: `irq_prioritizer`

## Requirements
- R1: Only bus lines 1 to 15 are monitored. Bit 0 of the pending, level, mask and force registers always reads as 0, so a pulse on line 0 or a write to bit 0 never produces a request.
- R2: A high level on line k (k = 1 to 15) sets pending bit k. The bit stays set after the line falls, until a write clears it or an acknowledge clears it.
- R3: A line that is high for one clock cycle only is captured in the pending register.
- R4: A level bit of 1 places its source in level 1. Any candidate in level 1 is chosen before every candidate in level 0, whatever the line numbers.
- R5: Among candidates of the same level, the highest line number is chosen.
- R6: Processor p's candidate set is (pending OR force[p]) AND mask[p]. A cleared mask bit blocks that source for processor p only.
- R7: Force bits of processor p make the source a candidate for processor p alone, even when the source is not pending.
- R8: When ack_valid[p] is high with number k (k not 0), force[p] bit k is cleared if it is set; otherwise pending bit k is cleared. An acknowledge with number 0 has no effect.
- R9: When a set and a clear of the same bit fall in the same cycle (a line pulse against a clear, or a write set against an acknowledge), the bit ends up set.
- R10: The write port selects its register with wr_reg: 0 = pending, 1 = level, 2 = mask, 3 = force. With wr_clr = 0 the 1-bits of wr_data are set; with wr_clr = 1 they are cleared. For mask and force, wr_cpu selects the processor.
- R11: req_id is registered. It is 0 after reset, and in each cycle it shows the choice made from the register contents of the previous cycle. A pending bit set at edge n therefore shows on req_id after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Interrupt bus; bit k is line k |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 2 | Target register: 0 pending, 1 level, 2 mask, 3 force |
| wr_clr | input | 1 | 0 sets the 1-bits of wr_data, 1 clears them |
| wr_cpu | input | CPU_W | Processor selected for mask and force writes |
| wr_data | input | 16 | Bit pattern to set or clear |
| ack_valid | input | N_CPU | Acknowledge strobe per processor |
| ack_id | input | N_CPU*4 | Acknowledged number per processor, 4 bits each |
| req_id | output | N_CPU*4 | Registered request number per processor, 4 bits each; 0 means none |

## Verification
Directed cases try the selection against a set of stimuli. These are: a pulse on line 0; a single-cycle pulse; a line held high for several cycles; a low-numbered level-1 source against higher-numbered level-0 sources; and two processors with different masks and force bits. Together they separate level ordering from order by number, and system-wide pending state from per-processor state. Further cases place a line pulse or a write set in the same cycle as an acknowledge or clear of that bit, which shows whether the set takes priority. Constrained random traffic then mixes pulses, writes and acknowledges of the current request number. Each cycle is compared with a reference model that takes the one-cycle output latency into account.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int SRC_N = 16;
    localparam int ID_W  = 4;

    typedef enum logic [1:0] {
        TGT_PEND  = 2'd0,
        TGT_LEVEL = 2'd1,
        TGT_MASK  = 2'd2,
        TGT_FORCE = 2'd3
    } wr_tgt_e;

    // highest set index among 1..SRC_N-1, 0 when empty
    function automatic logic [ID_W-1:0] top_index(input logic [SRC_N-1:0] v);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = 1; i < SRC_N; i++) begin
            if (v[i]) r = ID_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import irq_prio_pkg::*;
(
    input  logic [SRC_N-1:0] cand,
    input  logic [SRC_N-1:0] level_q,
    output logic [ID_W-1:0]  pick_id
);
    logic [SRC_N-1:0] hi_set;
    logic [SRC_N-1:0] lo_set;

    always_comb begin
        hi_set = cand & level_q;
        lo_set = cand & ~level_q;
        pick_id = (|hi_set) ? top_index(hi_set) : top_index(lo_set);
    end
endmodule

// File: rtl/irq_src_store.sv
module irq_src_store
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] irq_lines,
    input  logic             wr_en,
    input  wr_tgt_e          wr_tgt,
    input  logic             wr_clr,
    input  logic [SRC_N-1:0] wr_data,
    input  logic [SRC_N-1:0] ack_clr,
    output logic [SRC_N-1:0] pend_q,
    output logic [SRC_N-1:0] level_q
);
    localparam logic [SRC_N-1:0] LIVE = ~SRC_N'(1);

    logic [SRC_N-1:0] pend_set, pend_clr, lvl_set, lvl_clr;

    always_comb begin
        pend_set = '0;
        pend_clr = '0;
        lvl_set  = '0;
        lvl_clr  = '0;
        if (wr_en) begin
            unique case (wr_tgt)
                TGT_PEND:  if (wr_clr) pend_clr = wr_data; else pend_set = wr_data;
                TGT_LEVEL: if (wr_clr) lvl_clr = wr_data; else lvl_set = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            level_q <= '0;
        end else begin
            pend_q  <= ((pend_q & ~pend_clr & ~ack_clr) | pend_set | irq_lines) & LIVE;
            level_q <= ((level_q & ~lvl_clr) | lvl_set) & LIVE;
        end
    end
endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane
    import irq_prio_pkg::*;
#(
    parameter int CPU_W  = 1,
    parameter int CPU_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] pend_q,
    input  logic [SRC_N-1:0] level_q,
    input  logic             wr_en,
    input  wr_tgt_e          wr_tgt,
    input  logic             wr_clr,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [SRC_N-1:0] wr_data,
    input  logic             ack_valid,
    input  logic [ID_W-1:0]  ack_id,
    output logic [SRC_N-1:0] pend_ack_clr,
    output logic [SRC_N-1:0] mask_q,
    output logic [SRC_N-1:0] force_q,
    output logic [ID_W-1:0]  req_q
);
    localparam logic [SRC_N-1:0] LIVE = ~SRC_N'(1);
    localparam logic [CPU_W-1:0] MY_ID = CPU_W'(CPU_ID);

    logic             sel;
    logic [SRC_N-1:0] ack_hit, force_ack;
    logic [SRC_N-1:0] msk_set, msk_clr, frc_set, frc_clr;
    logic [SRC_N-1:0] cand;
    logic [ID_W-1:0]  pick_id;

    always_comb begin
        sel     = wr_en && (wr_cpu == MY_ID);
        ack_hit = '0;
        if (ack_valid && ack_id != '0) ack_hit[ack_id] = 1'b1;
        force_ack    = ack_hit & force_q;
        pend_ack_clr = ack_hit & ~force_q;
        msk_set = '0;
        msk_clr = '0;
        frc_set = '0;
        frc_clr = '0;
        if (sel) begin
            unique case (wr_tgt)
                TGT_MASK:  if (wr_clr) msk_clr = wr_data; else msk_set = wr_data;
                TGT_FORCE: if (wr_clr) frc_clr = wr_data; else frc_set = wr_data;
                default: ;
            endcase
        end
        cand = (pend_q | force_q) & mask_q;
    end

    irq_level_pick u_pick (
        .cand    (cand),
        .level_q (level_q),
        .pick_id (pick_id)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            force_q <= '0;
            req_q   <= '0;
        end else begin
            mask_q  <= ((mask_q & ~msk_clr) | msk_set) & LIVE;
            force_q <= ((force_q & ~frc_clr & ~force_ack) | frc_set) & LIVE;
            req_q   <= pick_id;
        end
    end
endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
    import irq_prio_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_N-1:0]        irq_lines,
    input  logic                    wr_en,
    input  logic [1:0]              wr_reg,
    input  logic                    wr_clr,
    input  logic [CPU_W-1:0]        wr_cpu,
    input  logic [SRC_N-1:0]        wr_data,
    input  logic [N_CPU-1:0]        ack_valid,
    input  logic [N_CPU*ID_W-1:0]   ack_id,
    output logic [N_CPU*ID_W-1:0]   req_id
);
    wr_tgt_e                  wr_tgt;
    logic [SRC_N-1:0]         pend_q, level_q, ack_clr_all;
    logic [N_CPU*SRC_N-1:0]   lane_ack_clr, mask_all, force_all;

    assign wr_tgt = wr_tgt_e'(wr_reg);

    always_comb begin
        ack_clr_all = '0;
        for (int p = 0; p < N_CPU; p++) begin
            ack_clr_all = ack_clr_all | lane_ack_clr[p*SRC_N +: SRC_N];
        end
    end

    irq_src_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .wr_en     (wr_en),
        .wr_tgt    (wr_tgt),
        .wr_clr    (wr_clr),
        .wr_data   (wr_data),
        .ack_clr   (ack_clr_all),
        .pend_q    (pend_q),
        .level_q   (level_q)
    );

    for (genvar p = 0; p < N_CPU; p++) begin : g_lane
        irq_cpu_lane #(.CPU_W(CPU_W), .CPU_ID(p)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .pend_q       (pend_q),
            .level_q      (level_q),
            .wr_en        (wr_en),
            .wr_tgt       (wr_tgt),
            .wr_clr       (wr_clr),
            .wr_cpu       (wr_cpu),
            .wr_data      (wr_data),
            .ack_valid    (ack_valid[p]),
            .ack_id       (ack_id[p*ID_W +: ID_W]),
            .pend_ack_clr (lane_ack_clr[p*SRC_N +: SRC_N]),
            .mask_q       (mask_all[p*SRC_N +: SRC_N]),
            .force_q      (force_all[p*SRC_N +: SRC_N]),
            .req_q        (req_id[p*ID_W +: ID_W])
        );
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter int N_CPU = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [SRC_N-1:0]      irq_lines,
    input logic [SRC_N-1:0]      pend_q,
    input logic [SRC_N-1:0]      level_q,
    input logic [N_CPU*SRC_N-1:0] mask_all,
    input logic [N_CPU*SRC_N-1:0] force_all,
    input logic [N_CPU*ID_W-1:0] req_id
);
    logic [N_CPU*SRC_N-1:0] cand_prev;
    logic [SRC_N-1:0]       level_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_prev  <= '0;
            level_prev <= '0;
        end else begin
            level_prev <= level_q;
            for (int p = 0; p < N_CPU; p++) begin
                cand_prev[p*SRC_N +: SRC_N] <= (pend_q | force_all[p*SRC_N +: SRC_N])
                                               & mask_all[p*SRC_N +: SRC_N];
            end
        end
    end

    AST_BIT0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] && !level_q[0]); // R1

    for (genvar k = 1; k < SRC_N; k++) begin : g_src
        AST_PULSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            irq_lines[k] |=> pend_q[k]); // R3
    end

    for (genvar p = 0; p < N_CPU; p++) begin : g_cpu
        AST_REQ_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
            req_id[p*ID_W +: ID_W] != '0 |->
                cand_prev[p*SRC_N + int'(req_id[p*ID_W +: ID_W])]); // R6
        AST_LEVEL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            (req_id[p*ID_W +: ID_W] != '0 && !level_prev[req_id[p*ID_W +: ID_W]]) |->
                ((cand_prev[p*SRC_N +: SRC_N] & level_prev) == '0)); // R4
        AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_prev[p*SRC_N +: SRC_N] == '0) |-> (req_id[p*ID_W +: ID_W] == '0)); // R11
    end
endmodule

bind irq_prioritizer irq_prio_chk #(.N_CPU(N_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .pend_q    (pend_q),
    .level_q   (level_q),
    .mask_all  (mask_all),
    .force_all (force_all),
    .req_id    (req_id)
);

// File: tb/irq_prioritizer_tb.sv
module irq_prioritizer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int CW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   irq_lines = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_reg = '0;
    logic          wr_clr = 1'b0;
    logic [CW-1:0] wr_cpu = '0;
    logic [15:0]   wr_data = '0;
    logic [NC-1:0] ack_valid = '0;
    logic [NC*4-1:0] ack_id = '0;
    logic [NC*4-1:0] req_id;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] m_pend = '0, m_lvl = '0;
    logic [15:0] m_mask [NC];
    logic [15:0] m_force [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prioritizer #(.N_CPU(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(wr_en),
        .wr_reg(wr_reg), .wr_clr(wr_clr), .wr_cpu(wr_cpu), .wr_data(wr_data),
        .ack_valid(ack_valid), .ack_id(ack_id), .req_id(req_id)
    );

    function automatic logic [3:0] ref_pick(logic [15:0] c, logic [15:0] l);
        for (int i = 15; i >= 1; i--) if (c[i] && l[i]) return 4'(i);
        for (int i = 15; i >= 1; i--) if (c[i] && !l[i]) return 4'(i);
        return 4'd0;
    endfunction

    function automatic logic [15:0] apply_wr(logic [15:0] v, logic hit, logic [15:0] d, logic c);
        if (!hit) return v;
        return c ? (v & ~d) : (v | d);
    endfunction

    task automatic check(string tag, int cpu, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cpu%0d req=%0d expected=%0d", tag, cpu, act, exp);
        end
    endtask

    // one clock: model the register update, then compare outputs after the edge
    task automatic step(string tag);
        logic [3:0]  exp [NC];
        logic [15:0] pclr, fack, nforce [NC];
        pclr = '0;
        for (int p = 0; p < NC; p++) begin
            exp[p] = ref_pick((m_pend | m_force[p]) & m_mask[p], m_lvl);
            fack = '0;
            if (ack_valid[p] && ack_id[p*4 +: 4] != 0) begin
                if (m_force[p][ack_id[p*4 +: 4]]) fack[ack_id[p*4 +: 4]] = 1'b1;
                else pclr[ack_id[p*4 +: 4]] = 1'b1;
            end
            nforce[p] = apply_wr(m_force[p] & ~fack, wr_en && wr_reg == 2'd3 && wr_cpu == CW'(p),
                                 wr_data, wr_clr) & 16'hFFFE;
            m_mask[p] = apply_wr(m_mask[p], wr_en && wr_reg == 2'd2 && wr_cpu == CW'(p),
                                 wr_data, wr_clr) & 16'hFFFE;
        end
        for (int p = 0; p < NC; p++) m_force[p] = nforce[p];
        m_pend = (apply_wr(m_pend & ~pclr, wr_en && wr_reg == 2'd0, wr_data, wr_clr) | irq_lines) & 16'hFFFE;
        m_lvl  = apply_wr(m_lvl, wr_en && wr_reg == 2'd1, wr_data, wr_clr) & 16'hFFFE;
        @(posedge clk);
        #1;
        for (int p = 0; p < NC; p++) check(tag, p, req_id[p*4 +: 4], exp[p]);
        irq_lines = '0; wr_en = 0; wr_clr = 0; wr_data = '0; ack_valid = '0; ack_id = '0;
    endtask

    task automatic wr(logic [1:0] r, logic c, int cpu, logic [15:0] d);
        wr_en = 1; wr_reg = r; wr_clr = c; wr_cpu = CW'(cpu); wr_data = d;
    endtask

    task automatic ack(int cpu, int id);
        ack_valid[cpu] = 1'b1; ack_id[cpu*4 +: 4] = 4'(id);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < NC; p++) begin m_mask[p] = '0; m_force[p] = '0; end
        repeat (3) @(posedge clk);
        #1;
        for (int p = 0; p < NC; p++) check("R11 reset", p, req_id[p*4 +: 4], 4'd0);
        rst_n = 1;
        @(posedge clk); #1;

        wr(2'd2, 0, 0, 16'hFFFF); step("R10 mask0");
        wr(2'd2, 0, 1, 16'h00F0); step("R10 mask1");
        irq_lines = 16'h0001; step("R1 line0");
        wr(2'd0, 0, 0, 16'h0001); step("R1 wr bit0");
        step("R1 idle");
        irq_lines[3] = 1'b1; step("R3 pulse");
        step("R11 latency");
        step("R3 held");
        for (int i = 0; i < 4; i++) begin irq_lines[9] = 1'b1; step("R2 high"); end
        step("R2 fallen"); step("R2 kept");
        irq_lines[5] = 1'b1; step("R6 pulse5");
        wr(2'd1, 0, 0, 16'h0004); step("R4 level");
        irq_lines[2] = 1'b1; step("R4 pulse2");
        step("R4 lvl1 wins"); step("R6 cpu1 mask");
        irq_lines[12] = 1'b1; step("R5 pulse12");
        step("R5 highest"); step("R5 hold");
        wr(2'd3, 0, 1, 16'h0040); step("R7 force");
        step("R7 cpu1 only"); step("R7 hold");
        ack(1, 6); step("R8 ack force");
        step("R8 force gone"); step("R8 pend kept");
        ack(0, 2); step("R8 ack pend");
        step("R8 pend gone");
        ack(0, 0); step("R8 ack zero");
        ack(0, 12); irq_lines[12] = 1'b1; step("R9 ack vs pulse");
        step("R9 set wins");
        wr(2'd0, 1, 0, 16'h0200); irq_lines[9] = 1'b1; step("R9 clr vs pulse");
        step("R9 set kept");
        wr(2'd3, 0, 0, 16'h0400); ack(0, 10); step("R9 force set vs ack");
        step("R9 force kept");
        wr(2'd0, 1, 0, 16'hFFFF); step("R10 clr pend");
        step("R10 cleared");

        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 3) == 0) irq_lines[$urandom_range(0, 15)] = 1'b1;
            if ($urandom_range(0, 5) == 0)
                wr(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom_range(0, NC-1),
                   16'($urandom_range(0, 65535)) & 16'($urandom_range(0, 65535)));
            for (int p = 0; p < NC; p++)
                if ($urandom_range(0, 2) == 0) ack(p, int'(req_id[p*4 +: 4]));
            step("R5 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule